// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of a two-wire debug link. It produces the bit clock itself and runs exactly one transaction for each accepted command. The data line is bidirectional, so the block drives it through three separate signals: an output value, an output enable and an input. A command selects the debug port or the access port, chooses read or write, gives a two-bit register address, and carries 32 bits of write data. When the transaction ends, the block returns a one-cycle response. The response holds the three-bit acknowledge, the read data, a parity-error flag and a protocol-error flag.

A transaction has up to three phases, always in this order:

- an 8-bit request that the host drives;
- a 3-bit acknowledge that the target drives;
- a 33-bit data phase, which the host drives for a write and the target drives for a read.

Each time control of the line passes from one side to the other, the block inserts a turnaround of `trn_cfg+1` bit times. During a turnaround neither side drives the line. If the acknowledge is not OK, the block skips the data phase. It inserts one turnaround, finishes, and reports what it received.

The controller moves through these states. Each transition named here happens at the end of the last bit of the current state:

- IDLE goes to REQ when a command is accepted.
- REQ goes to TRN_A.
- TRN_A goes to ACK.
- ACK goes to one of three states:
  - RDATA for an OK read;
  - TRN_W for an OK write;
  - TRN_E for any other acknowledge.
- TRN_W goes to WDATA.
- RDATA goes to TRN_E.
- WDATA goes to DONE.
- TRN_E goes to DONE.
- DONE always goes back to IDLE after one cycle.

Top module: `swd_host_engine`

## Requirements
- R1: After reset and while idle, `cmd_ready` is 1, `rsp_valid` is 0, `swclk` is 0, and the host drives the line low (`swdio_oe`=1, `swdio_o`=0).
- R2: The request goes out LSB first as bits 0..7. The bits are: 1, port select (1 = access port), read flag (1 = read), `cmd_addr[0]`, `cmd_addr[1]`, the even parity of bits 1..4, 0, and 1.
- R3: The bit periods follow one another in this order: request, turnaround, acknowledge, then the data phase and its turnaround. `swdio_oe` is 1 only in request bits and write-data bits. It is 0 in turnaround, acknowledge and read-data bits.
- R4: Every turnaround lasts `trn_cfg+1` bit periods. `trn_cfg` is sampled when the command is accepted.
- R5: Write data goes out LSB first in 32 bits. A 33rd bit follows, equal to the XOR of the 32 data bits.
- R6: The acknowledge is sampled LSB first, with the first bit received going to `rsp_ack[0]`. `rsp_valid` is a single-cycle pulse that presents the result.
- R7: On an OK read (`rsp_ack`=3'b001), `rsp_rdata` holds the 32 sampled bits, with the first bit in bit 0. `rsp_perr` is 0 when the 33rd bit equals their XOR.
- R8: `rsp_perr` is 1 when an OK read has a 33rd bit that does not match. It is never 1 unless `rsp_ack` is OK.
- R9: For WAIT (3'b010) and FAULT (3'b100), the data phase is skipped. The transaction lasts 8 + 2*(`trn_cfg`+1) + 3 bit periods.
- R10: `rsp_proto_err` is 1 exactly when `rsp_ack` is none of 3'b001, 3'b010 or 3'b100.
- R11: `cmd_valid` is ignored while `cmd_ready` is 0. It does not change the running transaction and does not start a new one.
- R12: The `swclk` period is 2*HALF_DIV clock cycles. `swdio_o` and `swdio_oe` change only when `swclk` falls, and `swdio_i` is sampled when `swclk` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle; the command is accepted |
| cmd_apndp | input | 1 | 1 selects the access port, 0 selects the debug port |
| cmd_rnw | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 2 | Register address bits 3:2 |
| cmd_wdata | input | 32 | Write data |
| trn_cfg | input | TRN_W | Turnaround length minus one |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ack | output | 3 | Received acknowledge |
| rsp_rdata | output | 32 | Read data |
| rsp_perr | output | 1 | Read-data parity mismatch |
| rsp_proto_err | output | 1 | Acknowledge is not a legal code |
| swclk | output | 1 | Serial bit clock |
| swdio_o | output | 1 | Line output value |
| swdio_oe | output | 1 | Line output enable |
| swdio_i | input | 1 | Line input value |

## Verification
A wrong state or a wrong bit count shows up on `swdio_oe` within one bit period. Either the enable pattern shifts against the expected request, turnaround and data windows, or the number of `swclk` pulses for the transaction comes out wrong. A bad decode of the acknowledge shows up when the engine reaches its response. It appears as a data phase where none belongs, or a missing one, and as the wrong `rsp_ack` or error flags. A mistake in the sampling position corrupts `rsp_rdata` or `rsp_perr` in the same response.

// File: rtl/swd_pkg.sv
package swd_pkg;
    localparam int DATA_W = 32;
    localparam int BCNT_W = 6;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_TRN_A,
        ST_ACK,
        ST_TRN_W,
        ST_WDATA,
        ST_RDATA,
        ST_TRN_E,
        ST_DONE
    } swd_state_e;
endpackage

// File: rtl/swd_bit_timer.sv
module swd_bit_timer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic swclk,
    output logic sample_stb,
    output logic bit_end
);
    localparam int PERIOD = 2 * HALF_DIV;
    localparam int CNT_W  = $clog2(PERIOD);

    logic [CNT_W-1:0] cnt_q;

    // rising edge of swclk coincides with the sample point
    assign sample_stb = run && (cnt_q == CNT_W'(HALF_DIV - 1));
    assign bit_end    = run && (cnt_q == CNT_W'(PERIOD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            swclk <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            swclk <= 1'b0;
        end else begin
            cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
            if (sample_stb)
                swclk <= 1'b1;
            else if (bit_end)
                swclk <= 1'b0;
        end
    end
endmodule

// File: rtl/swd_req_build.sv
module swd_req_build (
    input  logic       apndp,
    input  logic       rnw,
    input  logic [1:0] addr,
    output logic [7:0] req
);
    logic par;
    assign par = apndp ^ rnw ^ addr[0] ^ addr[1];
    // bit 0 leaves first: start, port, dir, a2, a3, parity, stop, park
    assign req = {1'b1, 1'b0, par, addr[1], addr[0], rnw, apndp, 1'b1};
endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
    import swd_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int TRN_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_apndp,
    input  logic              cmd_rnw,
    input  logic [1:0]        cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [TRN_W-1:0]  trn_cfg,
    output logic              rsp_valid,
    output logic [2:0]        rsp_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_perr,
    output logic              rsp_proto_err,
    output logic              swclk,
    output logic              swdio_o,
    output logic              swdio_oe,
    input  logic              swdio_i
);
    localparam logic [BCNT_W-1:0] REQ_LAST  = BCNT_W'(7);
    localparam logic [BCNT_W-1:0] ACK_LAST  = BCNT_W'(2);
    localparam logic [BCNT_W-1:0] DATA_LAST = BCNT_W'(DATA_W);

    swd_state_e        state_q, state_d, follow;
    logic [BCNT_W-1:0] bcnt_q, bcnt_d, last_idx;
    logic [7:0]        req_now, req_q;
    logic              rnw_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              rpar_q;
    logic [2:0]        ack_q;
    logic [TRN_W-1:0]  trn_q;
    logic              oe_q, o_q;
    logic              run, sample_stb, bit_end, accept, ack_ok;

    assign accept = (state_q == ST_IDLE) && cmd_valid;
    assign run    = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign ack_ok = (ack_q == ACK_OK);

    swd_bit_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run),
        .swclk(swclk), .sample_stb(sample_stb), .bit_end(bit_end)
    );

    swd_req_build u_req (
        .apndp(cmd_apndp), .rnw(cmd_rnw), .addr(cmd_addr), .req(req_now)
    );

    // last bit index of the current phase
    always_comb begin
        unique case (state_q)
            ST_REQ:                      last_idx = REQ_LAST;
            ST_ACK:                      last_idx = ACK_LAST;
            ST_WDATA, ST_RDATA:          last_idx = DATA_LAST;
            ST_TRN_A, ST_TRN_W, ST_TRN_E: last_idx = BCNT_W'(trn_q);
            default:                     last_idx = '0;
        endcase
    end

    // phase that follows the current one
    always_comb begin
        unique case (state_q)
            ST_REQ:   follow = ST_TRN_A;
            ST_TRN_A: follow = ST_ACK;
            ST_ACK:   follow = !ack_ok ? ST_TRN_E : (rnw_q ? ST_RDATA : ST_TRN_W);
            ST_TRN_W: follow = ST_WDATA;
            ST_RDATA: follow = ST_TRN_E;
            ST_WDATA: follow = ST_DONE;
            ST_TRN_E: follow = ST_DONE;
            default:  follow = ST_IDLE;
        endcase
    end

    always_comb begin
        state_d = state_q;
        bcnt_d  = bcnt_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) begin
                state_d = ST_REQ;
                bcnt_d  = '0;
            end
            ST_DONE: state_d = ST_IDLE;
            default: if (bit_end) begin
                if (bcnt_q != last_idx) begin
                    bcnt_d = bcnt_q + 1'b1;
                end else begin
                    bcnt_d  = '0;
                    state_d = follow;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            bcnt_q  <= bcnt_d;
        end
    end

    // line outputs, command capture and sampling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q    <= 1'b1;
            o_q     <= 1'b0;
            req_q   <= '0;
            rnw_q   <= 1'b0;
            wdata_q <= '0;
            trn_q   <= '0;
            ack_q   <= '0;
            rdata_q <= '0;
            rpar_q  <= 1'b0;
        end else begin
            if (accept) begin
                req_q   <= req_now;
                rnw_q   <= cmd_rnw;
                wdata_q <= cmd_wdata;
                trn_q   <= trn_cfg;
                ack_q   <= '0;
                oe_q    <= 1'b1;
                o_q     <= req_now[0];
            end else if (bit_end) begin
                unique case (state_d)
                    ST_REQ: begin
                        oe_q <= 1'b1;
                        o_q  <= req_q[bcnt_d[2:0]];
                    end
                    ST_WDATA: begin
                        oe_q <= 1'b1;
                        o_q  <= (bcnt_d == DATA_LAST) ? ^wdata_q : wdata_q[bcnt_d[4:0]];
                    end
                    ST_DONE, ST_IDLE: begin
                        oe_q <= 1'b1;
                        o_q  <= 1'b0;
                    end
                    default: begin
                        oe_q <= 1'b0;
                        o_q  <= 1'b0;
                    end
                endcase
            end
            if (sample_stb) begin
                if (state_q == ST_ACK)
                    ack_q[bcnt_q[1:0]] <= swdio_i;
                else if (state_q == ST_RDATA) begin
                    if (bcnt_q == DATA_LAST)
                        rpar_q <= swdio_i;
                    else
                        rdata_q[bcnt_q[4:0]] <= swdio_i;
                end
            end
        end
    end

    assign swdio_oe      = oe_q;
    assign swdio_o       = o_q;
    assign cmd_ready     = (state_q == ST_IDLE);
    assign rsp_valid     = (state_q == ST_DONE);
    assign rsp_ack       = ack_q;
    assign rsp_rdata     = rdata_q;
    assign rsp_perr      = rnw_q && ack_ok && ((^rdata_q) != rpar_q);
    assign rsp_proto_err = (ack_q != ACK_OK) && (ack_q != ACK_WAIT) && (ack_q != ACK_FAULT);
endmodule

// File: rtl/swd_host_checks.sv
module swd_host_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic       rsp_valid,
    input logic [2:0] rsp_ack,
    input logic       rsp_perr,
    input logic       rsp_proto_err,
    input logic       swclk,
    input logic       swdio_o,
    input logic       swdio_oe
);
    AST_LINE_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        swclk |-> ($stable(swdio_o) && $stable(swdio_oe))); // R12
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R6
    AST_READY_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> cmd_ready); // R11
    AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!swclk && swdio_oe)); // R1
    AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid) |=> (swdio_oe && swdio_o && !cmd_ready)); // R2
    AST_PROTO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_proto_err) |-> ($countones(rsp_ack) == 1)); // R10
    AST_PERR_NEEDS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_perr |-> (rsp_ack == 3'b001)); // R8
endmodule

bind swd_host_engine swd_host_checks u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_perr(rsp_perr),
    .rsp_proto_err(rsp_proto_err), .swclk(swclk), .swdio_o(swdio_o),
    .swdio_oe(swdio_oe)
);

// File: tb/sim_swd_host_engine.sv
`timescale 1ns/1ps
module sim_swd_host_engine;
    localparam int HALF = 2;
    localparam int NB   = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_apndp = 1'b0;
    logic        cmd_rnw = 1'b0;
    logic [1:0]  cmd_addr = '0;
    logic [31:0] cmd_wdata = '0;
    logic [1:0]  trn_cfg = '0;
    logic        cmd_ready, rsp_valid, rsp_perr, rsp_proto_err;
    logic [2:0]  rsp_ack;
    logic [31:0] rsp_rdata;
    logic        swclk, swdio_o, swdio_oe, swdio_i;

    int checks = 0;
    int fails  = 0;

    bit tgt_en [NB];
    bit tgt_v  [NB];
    bit cap_o  [NB];
    bit cap_oe [NB];
    bit exp_o  [NB];
    bit exp_oe [NB];
    int k = 0;
    int per_err = 0;
    time last_rise = 0;

    always #4 clk = ~clk;

    swd_host_engine #(.HALF_DIV(HALF), .TRN_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_apndp(cmd_apndp), .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .trn_cfg(trn_cfg), .rsp_valid(rsp_valid),
        .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr),
        .rsp_proto_err(rsp_proto_err), .swclk(swclk), .swdio_o(swdio_o),
        .swdio_oe(swdio_oe), .swdio_i(swdio_i)
    );

    // target model: pull-up when nobody drives
    assign swdio_i = (k < NB && tgt_en[k]) ? tgt_v[k] : 1'b1;

    always @(posedge swclk) begin
        if (k < NB) begin
            cap_o[k]  = swdio_o;
            cap_oe[k] = swdio_oe;
        end
        if (k > 0 && ($time - last_rise) != 2 * HALF * 8) per_err++;
        last_rise = $time;
    end
    always @(negedge swclk) k++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input bit apndp, input bit rnw, input logic [1:0] addr,
                           input logic [31:0] wd, input logic [1:0] trn,
                           input logic [2:0] ack, input logic [31:0] rd,
                           input bit badpar, input bit poke);
        int t = int'(trn) + 1;
        int n = 0;
        int base;
        int wait_cyc = 0;
        int mis_o = 0;
        int mis_oe = 0;
        int k_end;
        bit okack = (ack == 3'b001);
        logic [7:0] req;
        req = {1'b1, 1'b0, apndp ^ rnw ^ addr[0] ^ addr[1], addr[1], addr[0], rnw, apndp, 1'b1};
        for (int i = 0; i < NB; i++) begin
            tgt_en[i] = 0; tgt_v[i] = 0; exp_o[i] = 0; exp_oe[i] = 0;
            cap_o[i] = 0; cap_oe[i] = 0;
        end
        for (int i = 0; i < 8; i++) begin exp_oe[n] = 1; exp_o[n] = req[i]; n++; end
        n += t;
        for (int i = 0; i < 3; i++) begin tgt_en[n] = 1; tgt_v[n] = ack[i]; n++; end
        if (okack && rnw) begin
            for (int i = 0; i < 32; i++) begin tgt_en[n] = 1; tgt_v[n] = rd[i]; n++; end
            tgt_en[n] = 1; tgt_v[n] = (^rd) ^ badpar; n++;
            n += t;
        end else if (okack) begin
            n += t;
            for (int i = 0; i < 32; i++) begin exp_oe[n] = 1; exp_o[n] = wd[i]; n++; end
            exp_oe[n] = 1; exp_o[n] = ^wd; n++;
        end else begin
            n += t;
        end
        base = n;
        @(negedge clk);
        k = 0; per_err = 0;
        cmd_apndp = apndp; cmd_rnw = rnw; cmd_addr = addr; cmd_wdata = wd;
        trn_cfg = trn; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_apndp = ~apndp; cmd_addr = ~addr; cmd_wdata = ~wd; trn_cfg = ~trn;
        if (poke) begin
            repeat (6) @(negedge clk);
            cmd_valid = 1'b1;
            repeat (3) @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (!rsp_valid && wait_cyc < 2000) begin @(negedge clk); wait_cyc++; end
        chk(rsp_valid, "R6", "response seen", 32'(rsp_valid), 1);
        chk(rsp_ack == ack, "R6", "ack", 32'(rsp_ack), 32'(ack));
        chk(rsp_proto_err == !(ack == 3'b001 || ack == 3'b010 || ack == 3'b100),
            "R10", "proto err", 32'(rsp_proto_err), 0);
        chk(rsp_perr == (okack && rnw && badpar), "R7 R8", "parity err",
            32'(rsp_perr), 32'(okack && rnw && badpar));
        if (okack && rnw) chk(rsp_rdata == rd, "R7", "read data", rsp_rdata, rd);
        @(negedge clk);
        chk(!rsp_valid && cmd_ready, "R6", "pulse ends", 32'(rsp_valid), 0);
        repeat (3) @(negedge clk);
        chk(k == base, "R3 R4 R9", "bit periods", 32'(k), 32'(base));
        for (int i = 0; i < base && i < NB; i++) begin
            if (cap_oe[i] != exp_oe[i]) mis_oe++;
            if (exp_oe[i] && cap_o[i] != exp_o[i]) mis_o++;
        end
        chk(mis_oe == 0, "R3 R4", "enable mismatches", 32'(mis_oe), 0);
        chk(mis_o == 0, "R2 R5", "data mismatches", 32'(mis_o), 0);
        chk(per_err == 0, "R12", "swclk period errors", 32'(per_err), 0);
        k_end = k;
        if (poke) begin
            repeat (30) @(negedge clk);
            chk(k == k_end && cmd_ready, "R11", "no extra transaction", 32'(k), 32'(k_end));
        end
        chk(swdio_oe && !swdio_o && !swclk, "R1", "idle line", {30'b0, swdio_oe, swdio_o}, 2);
    endtask

    task automatic t_reset;
        chk(cmd_ready, "R1", "ready in reset", 32'(cmd_ready), 1);
        chk(!rsp_valid, "R1", "no response", 32'(rsp_valid), 0);
        chk(!swclk && swdio_oe && !swdio_o, "R1", "line idle",
            {29'b0, swclk, swdio_oe, swdio_o}, 2);
    endtask

    task automatic t_dp_write;    run_txn(0, 0, 2'b01, 32'hA5A5_0F0F, 2'd0, 3'b001, 0, 0, 0); endtask
    task automatic t_ap_read;     run_txn(1, 1, 2'b11, 32'h0, 2'd0, 3'b001, 32'h1234_5678, 0, 0); endtask
    task automatic t_read_perr;   run_txn(0, 1, 2'b00, 32'h0, 2'd0, 3'b001, 32'hFFFF_0001, 1, 0); endtask
    task automatic t_wait_write;  run_txn(1, 0, 2'b10, 32'hDEAD_BEEF, 2'd0, 3'b010, 0, 0, 0); endtask
    task automatic t_fault_read;  run_txn(1, 1, 2'b01, 32'h0, 2'd1, 3'b100, 32'h5555_AAAA, 0, 0); endtask
    task automatic t_no_target;   run_txn(0, 1, 2'b10, 32'h0, 2'd0, 3'b111, 0, 0, 0); endtask
    task automatic t_long_write;  run_txn(1, 0, 2'b11, 32'h8000_0001, 2'd3, 3'b001, 0, 0, 0); endtask
    task automatic t_long_read;   run_txn(0, 1, 2'b01, 32'h0, 2'd2, 3'b001, 32'h0F0F_F0F0, 0, 0); endtask
    task automatic t_busy_ignore; run_txn(0, 0, 2'b10, 32'h1357_9BDF, 2'd1, 3'b001, 0, 0, 1); endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_dp_write();
        t_ap_read();
        t_read_perr();
        t_wait_write();
        t_fault_read();
        t_no_target();
        t_long_write();
        t_long_read();
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule